// File: doc/BRIEF.md
# Transmit DMA Control and Status Register Block

This block holds the host-visible registers for the transmit side of a descriptor-driven packet DMA engine. A host reaches it through a simple single-cycle bus. The bus has a select, a write strobe, a byte address and 32-bit write data. Read data is combinational from the address. The block gives the engine a transmit enable level and a word-aligned pointer to the first transmit descriptor. The engine reads that pointer when the host turns transmission on.

The engine reports three kinds of event as single-cycle pulses: a packet completed, an empty descriptor was fetched (underrun), and the host bus returned a split, retry or error response. Completions drive a saturating packet counter. The host acknowledges packets one at a time by writing a one to bit 0 of the status word. The two error events set sticky flags, which the host clears by writing a one to them. Either error event also switches the transmit enable off in hardware, so the engine stops until the host enables it again.

Top module: `tx_dma_regs`

## Requirements
- R1: After reset, the enable output, the descriptor pointer output and every register read back as zero.
- R2: The control word at byte offset 0x0 holds the transmit enable in bit 0. It is written from write-data bit 0, and bits 31:1 read as zero.
- R3: An underrun or bus-error pulse forces the enable to 0 on the next clock edge. This also holds when the host writes a 1 to the enable in the same cycle.
- R4: The descriptor pointer word at byte offset 0x4 stores write-data bits 31:2. Bits 1:0 read as zero and are driven as zero on the pointer output.
- R5: The status word at byte offset 0x8 has this layout: packet count in bits 23:16, bus-error flag in bit 3, underrun flag in bit 1, packet-sent flag in bit 0. All other bits read as zero.
- R6: Each completion pulse adds one to the packet count. Each host write to the status word with data bit 0 set subtracts one. When both happen in the same cycle, the count is unchanged.
- R7: The packet count stops at 255 when incremented and stops at 0 when decremented.
- R8: The packet-sent flag reads 1 exactly when the packet count is non-zero.
- R9: An empty-descriptor pulse sets the underrun flag, and a bus-error pulse sets the bus-error flag.
- R10: A status write clears the underrun flag when data bit 1 is 1 and clears the bus-error flag when data bit 3 is 1. A data bit of 0 leaves its flag unchanged, and a set pulse in the same cycle overrides the clear.
- R11: Byte address 0xC, and any address other than the three listed, reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Host access select |
| bus_wr | input | 1 | Write strobe, valid with bus_sel |
| bus_addr | input | 4 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| ev_pkt_done | input | 1 | Engine pulse: one packet transferred |
| ev_desc_empty | input | 1 | Engine pulse: descriptor marked empty |
| ev_bus_err | input | 1 | Engine pulse: split, retry or error response |
| tx_enable | output | 1 | Transmit enable level to the engine |
| tx_desc_ptr | output | 32 | First descriptor address, bits 1:0 zero |

## Verification
The embedded properties check on every cycle that an error pulse turns the enable off, that the counter neither wraps past 255 nor drops below 0, that a completion and an acknowledge in the same cycle leave the count alone, that a flag set pulse wins over a clear, and that a flag or the pointer changes only when a write or event targets it. The field layout of the status word, the masking of reserved bits and address bits, the zero reads at unmapped addresses, and long runs that mix events and writes at random can only be shown by the bench. It reads all three words through the bus after every cycle and compares them with its behavioural model.

// File: rtl/txdr_pkg.sv
package txdr_pkg;
   typedef enum logic [1:0] {
      RSEL_CTRL = 2'd0,
      RSEL_DESC = 2'd1,
      RSEL_STAT = 2'd2,
      RSEL_NONE = 2'd3
   } txdr_rsel_e;

   localparam int unsigned STAT_SENT_BIT = 0;
   localparam int unsigned STAT_UR_BIT   = 1;
   localparam int unsigned STAT_BE_BIT   = 3;
   localparam int unsigned STAT_CNT_LSB  = 16;
   localparam int unsigned CTRL_EN_BIT   = 0;
   localparam int unsigned NUM_FLAGS     = 2;
endpackage

// File: rtl/txdr_decode.sv
module txdr_decode #(
   parameter int unsigned ADDR_W = 4,
   parameter logic [ADDR_W-1:0] CTRL_OFS = 'h0,
   parameter logic [ADDR_W-1:0] DESC_OFS = 'h4,
   parameter logic [ADDR_W-1:0] STAT_OFS = 'h8
) (
   input  logic              sel_i,
   input  logic              wr_i,
   input  logic [ADDR_W-1:0] addr_i,
   output logic              wr_ctrl_o,
   output logic              wr_desc_o,
   output logic              wr_stat_o,
   output txdr_pkg::txdr_rsel_e rsel_o
);
   import txdr_pkg::*;

   logic hit_ctrl, hit_desc, hit_stat, wr_en;

   assign hit_ctrl = (addr_i == CTRL_OFS);
   assign hit_desc = (addr_i == DESC_OFS);
   assign hit_stat = (addr_i == STAT_OFS);
   assign wr_en    = sel_i & wr_i;

   assign wr_ctrl_o = wr_en & hit_ctrl;
   assign wr_desc_o = wr_en & hit_desc;
   assign wr_stat_o = wr_en & hit_stat;

   always_comb begin
      if (hit_ctrl)      rsel_o = RSEL_CTRL;
      else if (hit_desc) rsel_o = RSEL_DESC;
      else if (hit_stat) rsel_o = RSEL_STAT;
      else               rsel_o = RSEL_NONE;
   end

   always_comb begin
      assert ($onehot0({wr_ctrl_o, wr_desc_o, wr_stat_o}))
         else $error("assert_one_write_target_R11 failed");
   end
endmodule

// File: rtl/txdr_ctrl.sv
module txdr_ctrl #(
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned ALIGN_BITS = 2
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en_i,
   input  logic                     en_wdata_i,
   input  logic                     err_i,
   input  logic                     wr_ptr_i,
   input  logic [DATA_W-1:ALIGN_BITS] ptr_wdata_i,
   output logic                     en_o,
   output logic [DATA_W-1:0]        ptr_o
);
   logic                       en_q;
   logic [DATA_W-1:ALIGN_BITS] ptr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        en_q <= 1'b0;
      else if (err_i)    en_q <= 1'b0;
      else if (wr_en_i)  en_q <= en_wdata_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        ptr_q <= '0;
      else if (wr_ptr_i) ptr_q <= ptr_wdata_i;
   end

   assign en_o  = en_q;
   assign ptr_o = {ptr_q, {ALIGN_BITS{1'b0}}};

   assert_ptr_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ptr_i |=> $stable(ptr_o));
   assert_enable_needs_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!en_o && !wr_en_i) |=> !en_o);
endmodule

// File: rtl/txdr_count.sv
module txdr_count #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc_i,
   input  logic             dec_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             nz_o
);
   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;
   logic             at_max, at_zero;

   assign at_max  = (cnt_q == CNT_MAX);
   assign at_zero = (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           cnt_q <= '0;
      else if (inc_i && !dec_i && !at_max)  cnt_q <= cnt_q + CNT_ONE;
      else if (dec_i && !inc_i && !at_zero) cnt_q <= cnt_q - CNT_ONE;
   end

   assign cnt_o = cnt_q;
   assign nz_o  = !at_zero;

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_o == CNT_MAX && inc_i && !dec_i) |=> (cnt_o == CNT_MAX));
   assert_no_underflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_o == '0 && dec_i && !inc_i) |=> (cnt_o == '0));
   assert_inc_dec_cancel_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc_i && dec_i) |=> $stable(cnt_o));
   assert_idle_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc_i && !dec_i) |=> $stable(cnt_o));
endmodule

// File: rtl/txdr_flag.sv
module txdr_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   logic q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= 1'b0;
      else if (set_i) q <= 1'b1;
      else if (clr_i) q <= 1'b0;
   end

   assign q_o = q;

   assert_set_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
   assert_flag_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (q_o && !clr_i) |=> q_o);
   assert_flag_needs_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!q_o && !set_i) |=> !q_o);
endmodule

// File: rtl/tx_dma_regs.sv
module tx_dma_regs #(
   parameter int unsigned ADDR_W     = 4,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned CNT_W      = 8,
   parameter int unsigned ALIGN_BITS = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              ev_pkt_done,
   input  logic              ev_desc_empty,
   input  logic              ev_bus_err,
   output logic              tx_enable,
   output logic [DATA_W-1:0] tx_desc_ptr
);
   import txdr_pkg::*;

   localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
   localparam logic [ADDR_W-1:0] OFS_DESC = ADDR_W'(4);
   localparam logic [ADDR_W-1:0] OFS_STAT = ADDR_W'(8);
   localparam int unsigned CNT_PAD = DATA_W - STAT_CNT_LSB - CNT_W;

   generate
      if (CNT_W < 1 || CNT_W > 8) begin : g_bad_cnt
         $error("tx_dma_regs: CNT_W must be 1..8");
      end
      if (DATA_W < STAT_CNT_LSB + CNT_W) begin : g_bad_data
         $error("tx_dma_regs: DATA_W too small for status layout");
      end
      if (ALIGN_BITS < 1 || ALIGN_BITS > STAT_BE_BIT) begin : g_bad_align
         $error("tx_dma_regs: ALIGN_BITS out of range");
      end
      if (ADDR_W < 4) begin : g_bad_addr
         $error("tx_dma_regs: ADDR_W must hold offset 0x8");
      end
   endgenerate

   logic       wr_ctrl, wr_desc, wr_stat, err_ev;
   txdr_rsel_e rsel;
   logic [CNT_W-1:0] pkt_cnt;
   logic             pkt_nz;
   logic [NUM_FLAGS-1:0] flag_set, flag_clr, flag_q;

   localparam int unsigned FLAG_POS [NUM_FLAGS] = '{STAT_UR_BIT, STAT_BE_BIT};

   txdr_decode #(
      .ADDR_W(ADDR_W), .CTRL_OFS(OFS_CTRL), .DESC_OFS(OFS_DESC), .STAT_OFS(OFS_STAT)
   ) u_decode (
      .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr),
      .wr_ctrl_o(wr_ctrl), .wr_desc_o(wr_desc), .wr_stat_o(wr_stat), .rsel_o(rsel)
   );

   assign err_ev = ev_desc_empty | ev_bus_err;

   txdr_ctrl #(.DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) u_ctrl (
      .clk(clk), .rst_n(rst_n),
      .wr_en_i(wr_ctrl), .en_wdata_i(bus_wdata[CTRL_EN_BIT]), .err_i(err_ev),
      .wr_ptr_i(wr_desc), .ptr_wdata_i(bus_wdata[DATA_W-1:ALIGN_BITS]),
      .en_o(tx_enable), .ptr_o(tx_desc_ptr)
   );

   txdr_count #(.CNT_W(CNT_W)) u_count (
      .clk(clk), .rst_n(rst_n),
      .inc_i(ev_pkt_done), .dec_i(wr_stat & bus_wdata[STAT_SENT_BIT]),
      .cnt_o(pkt_cnt), .nz_o(pkt_nz)
   );

   assign flag_set = {ev_bus_err, ev_desc_empty};

   for (genvar gi = 0; gi < NUM_FLAGS; gi++) begin : g_flag
      assign flag_clr[gi] = wr_stat & bus_wdata[FLAG_POS[gi]];
      txdr_flag u_flag (
         .clk(clk), .rst_n(rst_n),
         .set_i(flag_set[gi]), .clr_i(flag_clr[gi]), .q_o(flag_q[gi])
      );
   end

   logic [DATA_W-1:0] stat_word;
   always_comb begin
      stat_word = '0;
      stat_word[STAT_CNT_LSB +: CNT_W] = pkt_cnt;
      stat_word[STAT_SENT_BIT] = pkt_nz;
      for (int i = 0; i < int'(NUM_FLAGS); i++) stat_word[FLAG_POS[i]] = flag_q[i];
   end

   always_comb begin
      unique case (rsel)
         RSEL_CTRL: bus_rdata = {{(DATA_W-1){1'b0}}, tx_enable};
         RSEL_DESC: bus_rdata = tx_desc_ptr;
         RSEL_STAT: bus_rdata = stat_word;
         default:   bus_rdata = '0;
      endcase
   end

   assert_err_disables_R3: assert property (@(posedge clk) disable iff (!rst_n)
      err_ev |=> !tx_enable);
   assert_ptr_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
      tx_desc_ptr[ALIGN_BITS-1:0] == '0);
   assert_pad_unused_R5: assert property (@(posedge clk) disable iff (!rst_n)
      CNT_PAD < DATA_W |-> (rsel != RSEL_STAT || bus_rdata[2] == 1'b0));
endmodule

// File: tb/test_tx_dma_regs.sv
`timescale 1ns/1ps
module test_tx_dma_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0, bus_wr = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        ev_pkt_done = 1'b0, ev_desc_empty = 1'b0, ev_bus_err = 1'b0;
   logic        tx_enable;
   logic [31:0] tx_desc_ptr;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 1'b0;

   // reference model state
   bit       m_en;
   bit [29:0] m_ptr;
   int       m_cnt;
   bit       m_ur, m_be;

   always #2 clk = ~clk;

   tx_dma_regs i_tx_dma_regs (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .ev_pkt_done(ev_pkt_done), .ev_desc_empty(ev_desc_empty), .ev_bus_err(ev_bus_err),
      .tx_enable(tx_enable), .tx_desc_ptr(tx_desc_ptr)
   );

   task automatic check(string req, logic [31:0] got, logic [31:0] exp);
      n_tests++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   function automatic logic [31:0] exp_status();
      logic [31:0] s = '0;
      s[23:16] = 8'(m_cnt);
      s[3] = m_be;
      s[1] = m_ur;
      s[0] = (m_cnt != 0);
      return s;
   endfunction

   // compare all outputs and all readable words; called away from the clock edge
   task automatic compare_all();
      bus_sel = 1'b0; bus_wr = 1'b0;
      ev_pkt_done = 1'b0; ev_desc_empty = 1'b0; ev_bus_err = 1'b0;
      check("R2/R3 tx_enable", {31'b0, tx_enable}, {31'b0, m_en});
      check("R4 tx_desc_ptr", tx_desc_ptr, {m_ptr, 2'b00});
      bus_addr = 4'h0; #0.2;
      check("R2 ctrl read", bus_rdata, {31'b0, m_en});
      bus_addr = 4'h4; #0.2;
      check("R4 desc read", bus_rdata, {m_ptr, 2'b00});
      bus_addr = 4'h8; #0.2;
      check("R5/R6/R8/R9/R10 status read", bus_rdata, exp_status());
      bus_addr = 4'hC; #0.2;
      check("R11 unmapped read", bus_rdata, 32'h0);
   endtask

   // one clock cycle with the given stimulus, model update, then comparison
   task automatic cycle(bit sel, bit wr, logic [3:0] addr, logic [31:0] wd,
                        bit pd, bit de, bit be);
      bit wc, wp, ws, inc, dec;
      bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
      ev_pkt_done = pd; ev_desc_empty = de; ev_bus_err = be;
      @(posedge clk);
      wc = sel && wr && addr == 4'h0;
      wp = sel && wr && addr == 4'h4;
      ws = sel && wr && addr == 4'h8;
      if (de || be) m_en = 1'b0;
      else if (wc) m_en = wd[0];
      if (wp) m_ptr = wd[31:2];
      inc = pd; dec = ws && wd[0];
      if (inc && !dec && m_cnt < 255) m_cnt++;
      else if (dec && !inc && m_cnt > 0) m_cnt--;
      if (de) m_ur = 1'b1; else if (ws && wd[1]) m_ur = 1'b0;
      if (be) m_be = 1'b1; else if (ws && wd[3]) m_be = 1'b0;
      @(negedge clk);
      compare_all();
   endtask

   task automatic wr(logic [3:0] a, logic [31:0] d);
      cycle(1, 1, a, d, 0, 0, 0);
   endtask

   initial begin
      #40000;
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: got hung expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      m_en = 0; m_ptr = 0; m_cnt = 0; m_ur = 0; m_be = 0;
      repeat (3) @(negedge clk);
      // R1: reset state
      compare_all();
      rst_n = 1'b1;
      @(negedge clk);
      compare_all();

      // R2: enable write, reserved bits masked
      wr(4'h0, 32'hFFFF_FFFF);
      wr(4'h0, 32'hFFFF_FFFE);
      wr(4'h0, 32'h0000_0001);
      // R4: pointer low bits dropped
      wr(4'h4, 32'hDEAD_BEEF);
      wr(4'h4, 32'h1234_5677);
      // R11: unmapped writes leave registers alone
      wr(4'hC, 32'hFFFF_FFFF);
      wr(4'h2, 32'h0000_0000);
      // R3: underrun disables enable
      cycle(0, 0, 4'h0, 0, 0, 1, 0);
      // R3: host enable in same cycle as bus error
      cycle(1, 1, 4'h0, 32'h1, 0, 0, 1);
      wr(4'h0, 32'h1);
      // R10: write 0 leaves flags, write 1 clears
      wr(4'h8, 32'h0000_0000);
      wr(4'h8, 32'h0000_0002);
      wr(4'h8, 32'h0000_0008);
      // R10: set wins over clear
      cycle(1, 1, 4'h8, 32'h0000_000A, 0, 1, 1);
      wr(4'h8, 32'h0000_000A);
      // R6: increments, decrement, simultaneous
      repeat (3) cycle(0, 0, 4'h0, 0, 1, 0, 0);
      wr(4'h8, 32'h1);
      cycle(1, 1, 4'h8, 32'h1, 1, 0, 0);
      // R7: saturate at 255
      repeat (260) cycle(0, 0, 4'h0, 0, 1, 0, 0);
      // R7/R8: drain to zero and past
      repeat (258) wr(4'h8, 32'h1);
      // mixed random traffic
      for (int i = 0; i < 600; i++) begin
         logic [3:0] a;
         int r = $urandom_range(0, 3);
         a = (r == 3) ? 4'hC : 4'(r * 4);
         cycle($urandom_range(0, 1), $urandom_range(0, 1), a, $urandom(),
               $urandom_range(0, 2) != 0, $urandom_range(0, 15) == 0,
               $urandom_range(0, 15) == 0);
      end
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule